// File: doc/BRIEF.md
# Serial Flash Write-Protection Guard

This block sits between the command decoder and the program/erase sequencer of a 1-Mbit (131,072-byte) serial flash. For each decoded request it decides whether the request may proceed. It holds the write-enable latch and a 3-bit protection code that marks a power-of-two slice at the top of the array as read-only. Program requests are judged by their 256-byte page. Sector (4 KB) and block (32 KB) erases are judged by the whole span they would clear. A chip erase is refused whenever any protection is in force.

A hardware write-protect input locks only the protection code. While it is asserted, status writes are refused, but program and erase requests are still judged against the current code. Each gated request produces a one-cycle grant or deny pulse in the cycle after it is presented. It also always clears the write-enable latch.

Top module: `flash_wp_guard`

## Requirements
- R1: While reset is held and after its release, `wel`, `prot_code`, `grant` and `deny` are all 0.
- R2: `cmd_op` codes are 0 none, 1 latch set, 2 latch clear, 3 status write, 4 program, 5 sector erase, 6 block erase, 7 chip erase. A valid code 1 sets `wel` and a valid code 2 clears it. Neither code pulses `grant` or `deny`.
- R3: A gated request (codes 3 to 7) presented while `wel` is 0 is denied.
- R4: Every gated request clears `wel`, whether it is granted or denied.
- R5: A status write with `wel` set and `wp_assert` low loads `sr_code` into `prot_code` and is granted. With `wp_assert` high it is denied and `prot_code` keeps its value.
- R6: The protected region starts at byte 131072 − (131072 >> (6 − code)) for codes 1 to 5. Code 0 protects nothing. Codes 6 and 7 protect the whole array. A program request is denied if its page lies in the region.
- R7: A sector erase is denied if the 4 KB sector that holds `addr` overlaps the protected region.
- R8: A block erase is denied if the 32 KB block that holds `addr` overlaps the protected region.
- R9: A chip erase is denied whenever `prot_code` is nonzero and is granted (with `wel` set) when it is 0.
- R10: `grant` and `deny` are never high together. Each rises in the cycle after the request and lasts exactly one cycle. A denied request changes nothing except clearing `wel`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | A request is presented this cycle |
| cmd_op | input | 3 | Request code (see R2) |
| addr | input | 17 | Target byte address |
| sr_code | input | 3 | New protection code carried by a status write |
| wp_assert | input | 1 | Hardware write-protect, high = asserted |
| grant | output | 1 | One-cycle pulse: request accepted |
| deny | output | 1 | One-cycle pulse: request refused |
| wel | output | 1 | Write-enable latch |
| prot_code | output | 3 | Current protection code |

## Verification
Two things can happen in the same cycle, and both are tested together. A status write can meet an asserted write-protect pin while the latch is set. The latch clear can also fall in the same cycle as the deny that refused the request. The bench arms the latch and then presents a status write with the pin high. In the cycle that follows it expects a deny pulse, a cleared latch and an unchanged code, all seen together. Each erase size is also aimed at addresses on both sides of the protected boundary, and a single-cycle pulse is confirmed by sampling the cycle after.

// File: rtl/flash_wp_pkg.sv
package flash_wp_pkg;
  localparam int ADDR_W   = 17;
  localparam int CODE_W   = 3;
  localparam int PAGE_W   = 8;
  localparam int SECTOR_W = 12;
  localparam int BLOCK_W  = 15;
  localparam int FULL_CODE = 6;

  typedef enum logic [2:0] {
    OP_NONE   = 3'd0,
    OP_WEN    = 3'd1,
    OP_WDIS   = 3'd2,
    OP_STWR   = 3'd3,
    OP_PROG   = 3'd4,
    OP_SERASE = 3'd5,
    OP_BERASE = 3'd6,
    OP_CERASE = 3'd7
  } op_e;
endpackage

// File: rtl/flash_wp_bound.sv
module flash_wp_bound #(
  parameter int ADDR_W    = 17,
  parameter int CODE_W    = 3,
  parameter int FULL_CODE = 6
) (
  input  logic [CODE_W-1:0] code,
  output logic [ADDR_W:0]   bound
);
  localparam logic [ADDR_W:0] TOP = {1'b1, {ADDR_W{1'b0}}};
  localparam logic [CODE_W-1:0] FULL_C = CODE_W'(FULL_CODE);

  logic [CODE_W-1:0] shamt;

  always_comb begin
    shamt = FULL_C - code;
    if (code == '0) begin
      bound = TOP;
    end else if (code >= FULL_C) begin
      bound = '0;
    end else begin
      bound = TOP - (TOP >> shamt);
    end
  end
endmodule

// File: rtl/flash_wp_range.sv
module flash_wp_range
  import flash_wp_pkg::*;
#(
  parameter int ADDR_W   = 17,
  parameter int PAGE_W   = 8,
  parameter int SECTOR_W = 12,
  parameter int BLOCK_W  = 15
) (
  input  op_e              op,
  input  logic [ADDR_W-1:0] addr,
  input  logic [ADDR_W:0]   bound,
  input  logic              code_nz,
  output logic              hit
);
  localparam int NSPAN = 3;
  localparam int SPAN_W [NSPAN] = '{PAGE_W, SECTOR_W, BLOCK_W};

  logic [NSPAN-1:0] span_hit;

  for (genvar g = 0; g < NSPAN; g++) begin : g_span
    localparam logic [ADDR_W-1:0] MASK = ADDR_W'((1 << SPAN_W[g]) - 1);
    logic [ADDR_W:0] span_top;
    assign span_top    = {1'b0, addr | MASK};
    assign span_hit[g] = (span_top >= bound);
  end

  always_comb begin
    unique case (op)
      OP_PROG:   hit = span_hit[0];
      OP_SERASE: hit = span_hit[1];
      OP_BERASE: hit = span_hit[2];
      OP_CERASE: hit = code_nz;
      default:   hit = 1'b0;
    endcase
  end
endmodule

// File: rtl/flash_wp_state.sv
module flash_wp_state
  import flash_wp_pkg::*;
#(
  parameter int CODE_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              valid,
  input  op_e               op,
  input  logic              wp,
  input  logic              hit,
  input  logic [CODE_W-1:0] new_code,
  output logic              wel,
  output logic [CODE_W-1:0] code,
  output logic              grant,
  output logic              deny
);
  logic              gated, ok;
  logic              wel_en, wel_d;
  logic              code_en;
  logic              grant_d, deny_d;

  always_comb begin
    gated   = valid && (op inside {OP_STWR, OP_PROG, OP_SERASE, OP_BERASE, OP_CERASE});
    ok      = (op == OP_STWR) ? (wel && !wp) : (wel && !hit);
    wel_en  = gated || (valid && (op == OP_WEN || op == OP_WDIS));
    wel_d   = valid && (op == OP_WEN);
    code_en = gated && ok && (op == OP_STWR);
    grant_d = gated && ok;
    deny_d  = gated && !ok;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wel   <= 1'b0;
      code  <= '0;
      grant <= 1'b0;
      deny  <= 1'b0;
    end else begin
      if (wel_en)  wel  <= wel_d;
      if (code_en) code <= new_code;
      grant <= grant_d;
      deny  <= deny_d;
    end
  end
endmodule

// File: rtl/flash_wp_guard.sv
module flash_wp_guard
  import flash_wp_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  input  logic [2:0]        cmd_op,
  input  logic [ADDR_W-1:0] addr,
  input  logic [CODE_W-1:0] sr_code,
  input  logic              wp_assert,
  output logic              grant,
  output logic              deny,
  output logic              wel,
  output logic [CODE_W-1:0] prot_code
);
  logic [1:0]        rst_sync;
  logic              rst_q_n;
  logic [ADDR_W:0]   bound;
  logic              hit;
  op_e               op;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_q_n = rst_sync[1];
  assign op      = op_e'(cmd_op);

  flash_wp_bound #(.ADDR_W(ADDR_W), .CODE_W(CODE_W), .FULL_CODE(FULL_CODE)) u_bound (
    .code  (prot_code),
    .bound (bound)
  );

  flash_wp_range #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W), .SECTOR_W(SECTOR_W),
                   .BLOCK_W(BLOCK_W)) u_range (
    .op      (op),
    .addr    (addr),
    .bound   (bound),
    .code_nz (prot_code != '0),
    .hit     (hit)
  );

  flash_wp_state #(.CODE_W(CODE_W)) u_state (
    .clk      (clk),
    .rst_n    (rst_q_n),
    .valid    (cmd_valid),
    .op       (op),
    .wp       (wp_assert),
    .hit      (hit),
    .new_code (sr_code),
    .wel      (wel),
    .code     (prot_code),
    .grant    (grant),
    .deny     (deny)
  );
endmodule

// File: rtl/flash_wp_guard_chk.sv
module flash_wp_guard_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       cmd_valid,
  input logic [2:0] cmd_op,
  input logic       wp_assert,
  input logic       grant,
  input logic       deny,
  input logic       wel,
  input logic [2:0] prot_code
);
  AST_PULSE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(grant && deny)); // R10
  AST_WEN_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_op == 3'd1) |=> (wel && !grant && !deny)); // R2
  AST_NO_WEL_DENY: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_op >= 3'd3 && !wel) |=> deny); // R3
  AST_WEL_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_op >= 3'd3) |=> !wel); // R4
  AST_WP_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_op == 3'd3 && wp_assert) |=> (deny && $stable(prot_code))); // R5
  AST_CHIP_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_op == 3'd7 && prot_code != 3'd0) |=> deny); // R9
  AST_DENY_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
    deny |-> $stable(prot_code)); // R10
endmodule

bind flash_wp_guard flash_wp_guard_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .cmd_valid (cmd_valid),
  .cmd_op    (cmd_op),
  .wp_assert (wp_assert),
  .grant     (grant),
  .deny      (deny),
  .wel       (wel),
  .prot_code (prot_code)
);

// File: tb/flash_wp_guard_tb.sv
module flash_wp_guard_tb;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        cmd_valid;
  logic [2:0]  cmd_op;
  logic [16:0] addr;
  logic [2:0]  sr_code;
  logic        wp_assert;
  logic        grant, deny, wel;
  logic [2:0]  prot_code;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  flash_wp_guard u_dut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .addr(addr), .sr_code(sr_code), .wp_assert(wp_assert),
    .grant(grant), .deny(deny), .wel(wel), .prot_code(prot_code)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic issue(input logic [2:0] op, input logic [16:0] a,
                       input logic [2:0] d, input logic wp);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = op; addr = a; sr_code = d; wp_assert = wp;
    @(negedge clk);
    cmd_valid = 1'b0; cmd_op = 3'd0; wp_assert = 1'b0;
  endtask

  task automatic set_code(input logic [2:0] c);
    issue(3'd1, 17'd0, 3'd0, 1'b0);
    issue(3'd3, 17'd0, c, 1'b0);
    check("R5 code load", int'(prot_code), int'(c));
  endtask

  task automatic expect_result(input string req, input bit g);
    check({req, " grant"}, int'(grant), int'(g));
    check({req, " deny"},  int'(deny),  int'(!g));
    check({req, " wel cleared (R4)"}, int'(wel), 0);
  endtask

  task automatic guarded(input string req, input logic [2:0] op,
                         input logic [16:0] a, input bit g);
    issue(3'd1, 17'd0, 3'd0, 1'b0);
    issue(op, a, 3'd0, 1'b0);
    expect_result(req, g);
  endtask

  task automatic t_reset();
    cmd_valid = 1'b0; cmd_op = 3'd0; addr = '0; sr_code = '0; wp_assert = 1'b0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    check("R1 wel in reset", int'(wel), 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check("R1 wel", int'(wel), 0);
    check("R1 code", int'(prot_code), 0);
    check("R1 grant", int'(grant), 0);
    check("R1 deny", int'(deny), 0);
  endtask

  task automatic t_latch();
    issue(3'd1, 17'd0, 3'd0, 1'b0);
    check("R2 set wel", int'(wel), 1);
    check("R2 no pulse", int'(grant | deny), 0);
    issue(3'd2, 17'd0, 3'd0, 1'b0);
    check("R2 clear wel", int'(wel), 0);
    check("R2 no pulse clr", int'(grant | deny), 0);
  endtask

  task automatic t_no_wel();
    issue(3'd4, 17'd16, 3'd0, 1'b0);
    check("R3 deny w/o wel", int'(deny), 1);
    issue(3'd3, 17'd0, 3'd4, 1'b0);
    check("R3 status deny", int'(deny), 1);
    check("R3 code kept", int'(prot_code), 0);
  endtask

  task automatic t_wp_lock();
    set_code(3'd1);
    @(negedge clk);
    check("R10 grant one cycle", int'(grant), 0);
    issue(3'd1, 17'd0, 3'd0, 1'b0);
    issue(3'd3, 17'd0, 3'd3, 1'b1);
    expect_result("R5 wp lock", 1'b0);
    check("R5 code kept under wp", int'(prot_code), 1);
    @(negedge clk);
    check("R10 deny one cycle", int'(deny), 0);
  endtask

  task automatic t_program();
    // code 1: bound 0x1F000
    guarded("R6 prog below", 3'd4, 17'h1EFFF, 1'b1);
    guarded("R6 prog at bound", 3'd4, 17'h1F000, 1'b0);
    set_code(3'd5); // bound 0x10000
    guarded("R6 prog half below", 3'd4, 17'h0FFFF, 1'b1);
    guarded("R6 prog half at", 3'd4, 17'h10000, 1'b0);
    set_code(3'd6);
    guarded("R6 prog full", 3'd4, 17'h00000, 1'b0);
    set_code(3'd0);
    guarded("R6 prog none", 3'd4, 17'h1FFFF, 1'b1);
  endtask

  task automatic t_sector();
    set_code(3'd2); // bound 0x1E000
    guarded("R7 sector below", 3'd5, 17'h1DFFF, 1'b1);
    guarded("R7 sector in", 3'd5, 17'h1E005, 1'b0);
  endtask

  task automatic t_block();
    set_code(3'd3); // bound 0x1C000
    guarded("R8 block overlap", 3'd6, 17'h18000, 1'b0);
    guarded("R8 block clear", 3'd6, 17'h17FFF, 1'b1);
  endtask

  task automatic t_chip();
    guarded("R9 chip protected", 3'd7, 17'h00000, 1'b0);
    check("R10 code after deny", int'(prot_code), 3);
    set_code(3'd0);
    guarded("R9 chip open", 3'd7, 17'h00000, 1'b1);
  endtask

  initial begin
    fork
      begin
        t_reset();
        t_latch();
        t_no_wel();
        t_wp_lock();
        t_program();
        t_sector();
        t_block();
        t_chip();
        done = 1'b1;
      end
      begin
        repeat (20000) @(posedge clk);
        if (!done) begin
          checks++;
          errors++;
          $display("FAIL watchdog actual=0 expected=1");
        end
      end
    join_any
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule